// File: doc/BRIEF.md
# Package idle-state sequencing controller

This controller puts the shared package resources into a deep, fast idle state with no software involved. Each core reports one shallow-idle flag. When every flag is set and no wake request is present, the controller starts entry on its own. It first asks every I/O and memory link to go to standby. Once all links acknowledge, it asks the cache/mesh voltage domain to drop to its retention level. It reports the deep package state only after that retention request is acknowledged. The PLL enable stays high throughout, so leaving the state never waits for a relock.

Exit runs in the opposite order. The controller restores the retention voltage, waits for that acknowledgement to fall, and then releases the links. A core that leaves idle or a wake request during entry aborts it, and only the steps already taken are undone. Every handshake step has a timeout. A timeout returns the controller to the active state and sets a sticky fault. The total time spent in transition steps is compared against a budget, and an overrun sets a sticky error flag. A residency counter counts the cycles spent in the deep state. It can be read through a one-bit-address register port, which also returns the two flags.

All handshakes are level request/acknowledge pairs. A request stays at its level until the matching acknowledgement reaches the same level. There is no data stream and so no back-pressure.

Top module: `pkg_idle_seq`

## Requirements
- R1: Entry starts only while every bit of `core_idle` is 1 and `wake_req` is 0. With any core busy or a wake pending, all requests stay 0 and `pkg_deep` stays 0.
- R2: `link_stby_req` goes high within RESP_CYC cycles after the entry condition becomes true. The design takes 2 cycles.
- R3: Entry first drives every `link_stby_req` bit to 1. `ret_req` rises only after every `link_stby_ack` bit has been seen at 1.
- R4: `pkg_deep` rises only after `ret_ack` has been seen at 1 while `ret_req` is high.
- R5: From the deep state, a wake request or any busy core clears `pkg_deep` on the next cycle. `ret_req` then falls while the links are still requested. The links are released only after `ret_ack` is back at 0.
- R6: An abort during entry undoes only the completed steps. An abort while waiting for the link acknowledgements never raises `ret_req`. Neither kind of abort raises `pkg_deep` or sets `fault`.
- R7: `pll_en` is 1 in every state, from reset onward.
- R8: A handshake step whose acknowledgement does not arrive within STEP_TMO cycles returns the controller to the active state with all requests at 0. It also sets `fault`. `fault` stays at 1 until reset and blocks any further entry.
- R9: If the cycles spent in entry and exit steps, not counting cycles in the deep state, reach BUDGET_CYC, `budget_err` is set. It stays at 1 until reset. A normal sequence with one-cycle acknowledgements leaves it at 0.
- R10: With `reg_addr`=0, `reg_rdata` returns the residency count. The count rises by exactly one for each cycle spent in the deep state. With `reg_addr`=1, `reg_rdata` bit 0 is `fault`, bit 1 is `budget_err`, and the other bits are 0.
- R11: After reset all requests are 0, `pkg_deep`, `fault` and `budget_err` are 0, the residency count is 0, and `pll_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_idle | input | NUM_CORES | Per-core shallow-idle flag |
| wake_req | input | 1 | External wake request |
| link_stby_req | output | NUM_LINKS | Standby request per link |
| link_stby_ack | input | NUM_LINKS | Standby acknowledgement per link |
| ret_req | output | 1 | Cache/mesh retention-voltage request |
| ret_ack | input | 1 | Retention acknowledgement |
| pkg_deep | output | 1 | Package is in the deep idle state |
| pll_en | output | 1 | PLL enable, always high |
| fault | output | 1 | Sticky step-timeout fault |
| budget_err | output | 1 | Sticky transition-budget overrun |
| reg_addr | input | 1 | Register select: 0 residency, 1 flags |
| reg_rdata | output | RES_W | Register read data |

## Verification
The properties assume well-behaved domain stubs. Each acknowledgement only follows its own request, and `ret_ack` stays high for as long as `ret_req` is held in the deep state. The bench stubs copy each request to its acknowledgement after a settable latency. The stall tests freeze an acknowledgement and never raise one that was not requested. Core flags and wake change only at the falling clock edge, so the abort and response-time properties see stable inputs.

// File: rtl/pkg_idle_seq_pkg.sv
package pkg_idle_seq_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_ENTER_IO  = 3'd1,
    ST_ENTER_RET = 3'd2,
    ST_DEEP      = 3'd3,
    ST_EXIT_RET  = 3'd4,
    ST_EXIT_IO   = 3'd5
  } pis_state_e;
endpackage

// File: rtl/pis_idle_detect.sv
module pis_idle_detect #(
  parameter int NUM_CORES = 4,
  parameter int RESP_CYC  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_idle,
  input  logic                 wake_req,
  input  logic                 entry_ok,
  output logic                 go,
  output logic                 abort
);
  localparam int CW = $clog2(RESP_CYC + 2) + 1;

  logic all_idle;
  assign all_idle = (&core_idle) & ~wake_req;
  assign abort    = ~all_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go <= 1'b0;
    else        go <= all_idle;
  end

  // response-time watch: consecutive cycles of a met entry condition in ACTIVE
  logic [CW-1:0] wait_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cnt <= '0;
    else if (all_idle && entry_ok) wait_cnt <= wait_cnt + 1'b1;
    else                        wait_cnt <= '0;
  end

  p_resp_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CW'(RESP_CYC));
endmodule

// File: rtl/pis_step_timer.sv
module pis_step_timer #(
  parameter int STEP_TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(STEP_TMO + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear || !run)     cnt <= '0;
    else if (!expired)          cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == TW'(STEP_TMO - 1));
endmodule

// File: rtl/pis_residency.sv
module pis_residency #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_deep,
  output logic [RES_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (in_deep) count <= count + 1'b1;
  end
endmodule

// File: rtl/pkg_idle_seq.sv
module pkg_idle_seq
  import pkg_idle_seq_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_LINKS  = 3,
  parameter int RESP_CYC   = 4,
  parameter int STEP_TMO   = 16,
  parameter int BUDGET_CYC = 20,
  parameter int RES_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_idle,
  input  logic                 wake_req,
  output logic [NUM_LINKS-1:0] link_stby_req,
  input  logic [NUM_LINKS-1:0] link_stby_ack,
  output logic                 ret_req,
  input  logic                 ret_ack,
  output logic                 pkg_deep,
  output logic                 pll_en,
  output logic                 fault,
  output logic                 budget_err,
  input  logic                 reg_addr,
  output logic [RES_W-1:0]     reg_rdata
);
  localparam int BW = $clog2(BUDGET_CYC + 1);

  pis_state_e state, nxt;
  logic go, abort, expired, tmo_hit, run_step;
  logic [RES_W-1:0] resid;
  logic [BW-1:0] bud_cnt;

  pis_idle_detect #(.NUM_CORES(NUM_CORES), .RESP_CYC(RESP_CYC)) u_detect (
    .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .wake_req(wake_req),
    .entry_ok((state == ST_ACTIVE) && !fault), .go(go), .abort(abort));

  assign run_step = (state != ST_ACTIVE) && (state != ST_DEEP);

  pis_step_timer #(.STEP_TMO(STEP_TMO)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(nxt != state), .run(run_step),
    .expired(expired));

  pis_residency #(.RES_W(RES_W)) u_resid (
    .clk(clk), .rst_n(rst_n), .in_deep(state == ST_DEEP), .count(resid));

  always_comb begin
    nxt     = state;
    tmo_hit = 1'b0;
    case (state)
      ST_ACTIVE:    if (go && !fault) nxt = ST_ENTER_IO;
      ST_ENTER_IO:  if (abort)                nxt = ST_EXIT_IO;
                    else if (&link_stby_ack)  nxt = ST_ENTER_RET;
                    else if (expired) begin nxt = ST_ACTIVE; tmo_hit = 1'b1; end
      ST_ENTER_RET: if (abort)                nxt = ST_EXIT_RET;
                    else if (ret_ack)         nxt = ST_DEEP;
                    else if (expired) begin nxt = ST_ACTIVE; tmo_hit = 1'b1; end
      ST_DEEP:      if (abort)                nxt = ST_EXIT_RET;
      ST_EXIT_RET:  if (!ret_ack)             nxt = ST_EXIT_IO;
                    else if (expired) begin nxt = ST_ACTIVE; tmo_hit = 1'b1; end
      ST_EXIT_IO:   if (~|link_stby_ack)      nxt = ST_ACTIVE;
                    else if (expired) begin nxt = ST_ACTIVE; tmo_hit = 1'b1; end
      default:      nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_ACTIVE;
      fault      <= 1'b0;
      budget_err <= 1'b0;
      bud_cnt    <= '0;
    end else begin
      state <= nxt;
      if (tmo_hit) fault <= 1'b1;
      if (state == ST_ACTIVE)                    bud_cnt <= '0;
      else if (run_step && bud_cnt != BW'(BUDGET_CYC)) bud_cnt <= bud_cnt + 1'b1;
      if (bud_cnt == BW'(BUDGET_CYC)) budget_err <= 1'b1;
    end
  end

  always_comb begin
    link_stby_req = {NUM_LINKS{(state == ST_ENTER_IO) || (state == ST_ENTER_RET) ||
                               (state == ST_DEEP) || (state == ST_EXIT_RET)}};
    ret_req  = (state == ST_ENTER_RET) || (state == ST_DEEP);
    pkg_deep = (state == ST_DEEP);
    pll_en   = 1'b1;
    reg_rdata = reg_addr ? {{(RES_W-2){1'b0}}, budget_err, fault} : resid;
  end

  p_link_before_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_req) |-> $past(&link_stby_ack));
  p_ret_before_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkg_deep) |-> $past(ret_ack));
  p_deep_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_deep && (wake_req || !(&core_idle))) |=> !pkg_deep);
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(|link_stby_req)) |=> !(|link_stby_req));
  p_budget_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    budget_err |=> budget_err);
endmodule

// File: tb/pkg_idle_seq_tb_top.sv
module pkg_idle_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] core_idle = '0;
  logic wake_req = 1'b0, ret_ack = 1'b0, reg_addr = 1'b0;
  logic [NL-1:0] link_ack = '0;
  logic [NL-1:0] link_req;
  logic ret_req, pkg_deep, pll_en, fault, budget_err;
  logic [31:0] rdata;

  int link_lat = 1, ret_lat = 1, lcnt = 0, rcnt = 0;
  int n_tests = 0, n_fail = 0;
  int pll_low = 0, order_bad = 0, deep_seen = 0, ret_seen = 0;
  logic prev_link = 1'b0, prev_ret = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkg_idle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .wake_req(wake_req),
    .link_stby_req(link_req), .link_stby_ack(link_ack), .ret_req(ret_req),
    .ret_ack(ret_ack), .pkg_deep(pkg_deep), .pll_en(pll_en), .fault(fault),
    .budget_err(budget_err), .reg_addr(reg_addr), .reg_rdata(rdata));

  // acknowledging stubs with settable latency (very large = stalled)
  always @(posedge clk) begin
    if (link_ack != link_req) begin
      if (lcnt >= link_lat - 1) begin link_ack <= link_req; lcnt <= 0; end
      else lcnt <= lcnt + 1;
    end else lcnt <= 0;
    if (ret_ack != ret_req) begin
      if (rcnt >= ret_lat - 1) begin ret_ack <= ret_req; rcnt <= 0; end
      else rcnt <= rcnt + 1;
    end else rcnt <= 0;
  end

  // monitors sampled at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (!pll_en) pll_low++;
    if (pkg_deep) deep_seen++;
    if (ret_req) ret_seen++;
    if (prev_link && !(|link_req) && prev_ret) order_bad++;
    prev_link = |link_req;
    prev_ret  = ret_req;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; core_idle = '0; wake_req = 1'b0;
    link_lat = 1; ret_lat = 1;
    cyc(3); rst_n = 1'b1; cyc(1);
    deep_seen = 0; ret_seen = 0; order_bad = 0;
  endtask

  // vector: {core_idle[3:0], wake}
  localparam logic [4:0] VEC [8] = '{5'b1111_0, 5'b0111_0, 5'b1111_1, 5'b1000_0,
                                     5'b1111_0, 5'b1101_0, 5'b0000_1, 5'b1111_0};

  int r0, dcnt, t;
  bit exp_deep;

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check(link_req == 0 && !ret_req && !pkg_deep, "R11 requests idle", int'({link_req, ret_req, pkg_deep}), 0);
    check(!fault && !budget_err && pll_en, "R11 flags", int'({fault, budget_err, pll_en}), 1);
    reg_addr = 1'b0; #1;
    check(rdata == 0, "R11 residency", int'(rdata), 0);

    // R1 table walk
    foreach (VEC[i]) begin
      core_idle = VEC[i][4:1]; wake_req = VEC[i][0];
      exp_deep = (&VEC[i][4:1]) && !VEC[i][0];
      cyc(12);
      check(pkg_deep == exp_deep, "R1 deep per pattern", int'(pkg_deep), int'(exp_deep));
      check(link_req == (exp_deep ? '1 : '0), "R3 link requests", int'(link_req), exp_deep ? 7 : 0);
      core_idle = '0; wake_req = 1'b0; cyc(12);
      check(!pkg_deep && link_req == 0 && !ret_req, "R5 back to active", int'({link_req, ret_req}), 0);
    end
    check(order_bad == 0, "R5 retention released before links", order_bad, 0);
    check(!budget_err && !fault, "R9 normal sequence within budget", int'({fault, budget_err}), 0);

    // R2 response time
    core_idle = '1; cyc(1); t = 1;
    while (link_req == 0 && t < 10) begin cyc(1); t++; end
    check(t <= 4, "R2 entry response", t, 2);
    // R10 residency
    while (!pkg_deep) cyc(1);
    reg_addr = 1'b0; #1; r0 = int'(rdata); dcnt = 0;
    repeat (25) begin if (pkg_deep) dcnt++; cyc(1); end
    #1;
    check(int'(rdata) == r0 + dcnt, "R10 residency count", int'(rdata), r0 + dcnt);
    check(dcnt == 25, "R10 stayed deep", dcnt, 25);
    // R5 exit on wake
    wake_req = 1'b1; cyc(1);
    check(!pkg_deep && link_req == '1, "R5 deep drops, links held", int'({pkg_deep, link_req}), 7);
    cyc(10); wake_req = 1'b0; core_idle = '0; cyc(2);
    check(link_req == 0 && order_bad == 0, "R5 exit order", order_bad, 0);
    check(pll_low == 0, "R7 pll always on", pll_low, 0);

    // R6 abort while waiting link acks
    do_reset(); link_lat = 6;
    core_idle = '1; cyc(3); core_idle[2] = 1'b0; cyc(20);
    check(ret_seen == 0 && deep_seen == 0, "R6 abort in link step", ret_seen + deep_seen, 0);
    check(link_req == 0 && !fault, "R6 unwound links", int'({link_req, fault}), 0);
    // R6 abort while waiting retention ack
    link_lat = 1; ret_lat = 6; core_idle = '1;
    while (!ret_req) cyc(1);
    cyc(2); wake_req = 1'b1; cyc(20);
    check(deep_seen == 0 && !fault, "R6 abort in retention step", deep_seen, 0);
    check(link_req == 0 && !ret_req, "R6 unwound both", int'({link_req, ret_req}), 0);
    wake_req = 1'b0; core_idle = '0;

    // R9 budget overrun with slow acknowledgements
    do_reset(); link_lat = 5; ret_lat = 5; core_idle = '1;
    t = 0; while (!pkg_deep && t < 100) begin cyc(1); t++; end
    check(pkg_deep == 1'b1, "R9 slow entry reaches deep", int'(pkg_deep), 1);
    wake_req = 1'b1; cyc(40); wake_req = 1'b0; core_idle = '0; cyc(5);
    reg_addr = 1'b1; #1;
    check(rdata == 32'h2, "R9 budget flag via register", int'(rdata), 2);

    // R8 step timeout with stalled retention
    do_reset(); ret_lat = 100000; core_idle = '1; cyc(40);
    check(fault && link_req == 0 && !ret_req, "R8 timeout to active", int'({fault, link_req, ret_req}), 16);
    check(deep_seen == 0, "R8 no deep on timeout", deep_seen, 0);
    ret_lat = 1; cyc(30);
    check(link_req == 0 && fault, "R8 fault blocks re-entry", int'({fault, link_req}), 8);
    reg_addr = 1'b1; #1;
    check(rdata[0] == 1'b1, "R10 fault bit in register", int'(rdata), 1);
    check(pll_low == 0, "R7 pll after faults", pll_low, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule